// File: doc/BRIEF.md
# Flash Command Sequencer

This block carries out controller-driven flash operations on behalf of software. Software selects an operation (read, program or erase), a start word address and a word count, then pulses a start strobe. The sequencer then issues one request per flash word to a physical flash controller. Each request is held until the physical side answers with a done strobe.

Reads return data that the sequencer places into an internal read FIFO, which software drains. Program data comes from an internal program FIFO that software fills. A transfer may be far longer than either FIFO. The sequencer pauses when it has no room for read data or no program data to send, and it resumes by itself once software catches up.

Erase issues a single request that covers either one page or a whole bank. Level and full/empty conditions on both FIFOs, together with completion and error events, are presented as interrupt lines.

Top module: `flash_cmd_seq`

## Requirements
- R1: A read with `count_i` = N fetches N+1 words from addresses `addr_i`, `addr_i`+1, and so on, using `ph_op_o` = 0. The words reach `rd_data_o` in address order, and each is present while `rd_valid_o` is high.
- R2: No read request is raised while the read FIFO holds DEPTH entries. Fetching continues without a new start once software pops entries with `rd_pop_i`.
- R3: A program with `count_i` = N sends N+1 words, using `ph_op_o` = 1. Words leave the program FIFO in push order and go to consecutive addresses from `addr_i`. No request is raised while the program FIFO is empty, and the transfer resumes when more words are pushed.
- R4: While `ph_req_o` is high and `ph_done_i` is low, the request, `ph_op_o`, `ph_addr_o`, `ph_bank_o` and `ph_wdata_o` stay unchanged into the next cycle.
- R5: An erase (`op_i` = 2 or 3) issues exactly one request, with `ph_op_o` = 2, at `addr_i`. `ph_bank_o` equals `erase_bank_i`, where 1 selects the whole bank and 0 selects one page. `count_i` is ignored.
- R6: A start pulse is ignored while an operation is in progress or while `ph_init_busy_i` is high.
- R7: A done with `ph_err_i` high ends the operation at once. It sets `err_o` and `done_o` and pulses `irq_err_o` for one cycle. A read word that carries an error is not stored.
- R8: After the last word, `busy_o` falls, `done_o` is set, and `irq_done_o` pulses high for one cycle. An accepted start clears `done_o` and `err_o`.
- R9: `irq_rd_full_o` is high when the read FIFO holds DEPTH words. `irq_prog_empty_o` is high when the program FIFO is empty. `irq_rd_lvl_o` is high when the read count is at least `rd_lvl_i`. `irq_prog_lvl_o` is high when the program count is at most `prog_lvl_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| op_i | input | 2 | Operation: 0 read, 1 program, 2/3 erase |
| erase_bank_i | input | 1 | Erase scope: 1 bank, 0 page |
| addr_i | input | AW | Start word address |
| count_i | input | CNTW | Word count minus one |
| rd_pop_i | input | 1 | Pop one word from the read FIFO |
| rd_data_o | output | DW | Read FIFO head |
| rd_valid_o | output | 1 | Read FIFO not empty |
| prog_push_i | input | 1 | Push one word into the program FIFO |
| prog_data_i | input | DW | Word to push |
| prog_full_o | output | 1 | Program FIFO full |
| rd_lvl_i | input | LW | Read FIFO level threshold |
| prog_lvl_i | input | LW | Program FIFO level threshold |
| ph_req_o | output | 1 | Request to the physical controller |
| ph_op_o | output | 2 | Requested operation |
| ph_bank_o | output | 1 | Bank-wide erase flag |
| ph_addr_o | output | AW | Word address |
| ph_wdata_o | output | DW | Program data |
| ph_done_i | input | 1 | Request complete |
| ph_err_i | input | 1 | Request failed, valid with done |
| ph_rdata_i | input | DW | Read data, valid with done |
| ph_init_busy_i | input | 1 | Physical side still initializing |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished (status) |
| err_o | output | 1 | Operation ended in error (status) |
| irq_done_o | output | 1 | Completion pulse |
| irq_err_o | output | 1 | Error pulse |
| irq_rd_full_o | output | 1 | Read FIFO full |
| irq_rd_lvl_o | output | 1 | Read FIFO at or above threshold |
| irq_prog_empty_o | output | 1 | Program FIFO empty |
| irq_prog_lvl_o | output | 1 | Program FIFO at or below threshold |

## Verification
The start strobe is taken at the rising edge, so `busy_o` is high one cycle later. A request follows one cycle after the stall condition clears. A word answered at one edge is visible in the read FIFO, and its program word is gone from the program FIFO, right after that same edge. The four FIFO interrupts follow the fill counts combinationally. The bench drives every input and samples every output at the falling edge, where these results have settled. It waits for `busy_o` to drop, or for a fixed number of cycles during a stall, before it compares the logged physical requests and the FIFO contents with values computed from the address.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2} op_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_ACT = 2'd2} state_e;

  function automatic op_e decode_op(logic [1:0] code);
    if (code[1]) return OP_ERASE;
    return code[0] ? OP_PROG : OP_READ;
  endfunction
endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];
  assign count_o = cnt_q;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end
endmodule

// File: rtl/seq_irq.sv
module seq_irq #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] rd_cnt_i,
  input  logic [CW-1:0] prog_cnt_i,
  input  logic [CW-1:0] rd_lvl_i,
  input  logic [CW-1:0] prog_lvl_i,
  output logic          irq_rd_full_o,
  output logic          irq_rd_lvl_o,
  output logic          irq_prog_empty_o,
  output logic          irq_prog_lvl_o
);
  assign irq_rd_full_o    = (rd_cnt_i == CW'(DEPTH));
  assign irq_rd_lvl_o     = (rd_cnt_i >= rd_lvl_i);
  assign irq_prog_empty_o = (prog_cnt_i == '0);
  assign irq_prog_lvl_o   = (prog_cnt_i <= prog_lvl_i);
endmodule

// File: rtl/seq_core.sv
module seq_core import flash_seq_pkg::*; #(
  parameter int AW   = 16,
  parameter int CNTW = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic            bank_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [CNTW-1:0] count_i,
  input  logic            init_busy_i,
  input  logic            rd_full_i,
  input  logic            prog_empty_i,
  input  logic            ph_done_i,
  input  logic            ph_err_i,
  output logic            ph_req_o,
  output logic [1:0]      ph_op_o,
  output logic            ph_bank_o,
  output logic [AW-1:0]   ph_addr_o,
  output logic            rd_push_o,
  output logic            prog_pop_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            irq_done_o,
  output logic            irq_err_o
);
  state_e state_q;
  op_e op_q;
  logic bank_q, done_q, err_q, irq_done_q, irq_err_q;
  logic [AW-1:0] addr_q;
  logic [CNTW-1:0] left_q;
  logic accept, go, last, ok_done;

  always_comb begin
    accept = start_i && (state_q == ST_IDLE) && !init_busy_i;
    unique case (op_q)
      OP_READ: go = !rd_full_i;
      OP_PROG: go = !prog_empty_i;
      default: go = 1'b1;
    endcase
    last    = (left_q == '0) || (op_q == OP_ERASE);
    ok_done = (state_q == ST_ACT) && ph_done_i && !ph_err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_READ;
      bank_q     <= 1'b0;
      addr_q     <= '0;
      left_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      irq_done_q <= 1'b0;
      irq_err_q  <= 1'b0;
    end else begin
      irq_done_q <= 1'b0;
      irq_err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= decode_op(op_i);
          bank_q  <= bank_i;
          addr_q  <= addr_i;
          left_q  <= count_i;
          done_q  <= 1'b0;
          err_q   <= 1'b0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (go) state_q <= ST_ACT;
        ST_ACT: if (ph_done_i) begin
          if (ph_err_i || last) begin
            state_q    <= ST_IDLE;
            done_q     <= 1'b1;
            irq_done_q <= 1'b1;
            err_q      <= ph_err_i;
            irq_err_q  <= ph_err_i;
          end else begin
            addr_q  <= addr_q + 1'b1;
            left_q  <= left_q - 1'b1;
            state_q <= ST_WAIT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ph_req_o   = (state_q == ST_ACT);
  assign ph_op_o    = op_q;
  assign ph_bank_o  = bank_q;
  assign ph_addr_o  = addr_q;
  assign rd_push_o  = ok_done && (op_q == OP_READ);
  assign prog_pop_o = ok_done && (op_q == OP_PROG);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign irq_done_o = irq_done_q;
  assign irq_err_o  = irq_err_q;
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int CNTW  = 12,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic            erase_bank_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [CNTW-1:0] count_i,
  input  logic            rd_pop_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            rd_valid_o,
  input  logic            prog_push_i,
  input  logic [DW-1:0]   prog_data_i,
  output logic            prog_full_o,
  input  logic [LW-1:0]   rd_lvl_i,
  input  logic [LW-1:0]   prog_lvl_i,
  output logic            ph_req_o,
  output logic [1:0]      ph_op_o,
  output logic            ph_bank_o,
  output logic [AW-1:0]   ph_addr_o,
  output logic [DW-1:0]   ph_wdata_o,
  input  logic            ph_done_i,
  input  logic            ph_err_i,
  input  logic [DW-1:0]   ph_rdata_i,
  input  logic            ph_init_busy_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            irq_done_o,
  output logic            irq_err_o,
  output logic            irq_rd_full_o,
  output logic            irq_rd_lvl_o,
  output logic            irq_prog_empty_o,
  output logic            irq_prog_lvl_o
);
  logic rd_push, rd_full, rd_empty, prog_pop, prog_empty;
  logic [LW-1:0] rd_cnt, prog_cnt;

  seq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rd_fifo (
    .clk_i, .rst_ni,
    .push_i(rd_push), .wdata_i(ph_rdata_i), .pop_i(rd_pop_i),
    .rdata_o(rd_data_o), .count_o(rd_cnt), .full_o(rd_full), .empty_o(rd_empty)
  );

  seq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_prog_fifo (
    .clk_i, .rst_ni,
    .push_i(prog_push_i), .wdata_i(prog_data_i), .pop_i(prog_pop),
    .rdata_o(ph_wdata_o), .count_o(prog_cnt), .full_o(prog_full_o), .empty_o(prog_empty)
  );

  seq_core #(.AW(AW), .CNTW(CNTW)) u_core (
    .clk_i, .rst_ni,
    .start_i, .op_i, .bank_i(erase_bank_i), .addr_i, .count_i,
    .init_busy_i(ph_init_busy_i), .rd_full_i(rd_full), .prog_empty_i(prog_empty),
    .ph_done_i, .ph_err_i,
    .ph_req_o, .ph_op_o, .ph_bank_o, .ph_addr_o,
    .rd_push_o(rd_push), .prog_pop_o(prog_pop),
    .busy_o, .done_o, .err_o, .irq_done_o, .irq_err_o
  );

  seq_irq #(.DEPTH(DEPTH)) u_irq (
    .rd_cnt_i(rd_cnt), .prog_cnt_i(prog_cnt), .rd_lvl_i, .prog_lvl_i,
    .irq_rd_full_o, .irq_rd_lvl_o, .irq_prog_empty_o, .irq_prog_lvl_o
  );

  assign rd_valid_o = !rd_empty;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ph_req_o,
  input logic [1:0]    ph_op_o,
  input logic          ph_bank_o,
  input logic [AW-1:0] ph_addr_o,
  input logic [DW-1:0] ph_wdata_o,
  input logic          ph_done_i,
  input logic          ph_err_i,
  input logic          ph_init_busy_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          irq_done_o,
  input logic          irq_err_o,
  input logic          irq_rd_full_o,
  input logic          irq_prog_empty_o,
  input logic          rd_valid_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_req_o && !ph_done_i |=> ph_req_o && $stable(ph_addr_o) && $stable(ph_op_o)
      && $stable(ph_bank_o) && $stable(ph_wdata_o)); // R4
  AST_NO_READ_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_req_o && ph_op_o == 2'd0 |-> !irq_rd_full_o); // R2
  AST_NO_PROG_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_req_o && ph_op_o == 2'd1 |-> !irq_prog_empty_o); // R3
  AST_ERR_ENDS_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_err_o |-> err_o && done_o && !busy_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |=> !irq_done_o); // R8
  AST_INIT_BLOCKS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_init_busy_i && !busy_o |=> !busy_o); // R6
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_req_o |-> busy_o); // R8
  AST_FULL_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rd_full_o |-> rd_valid_o); // R9
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int AW = 8, DW = 16, CNTW = 6, DEPTH = 4, LW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, bank = 0, rd_pop = 0, prog_push = 0, init_busy = 0;
  logic [1:0] op = 0;
  logic [AW-1:0] addr = 0;
  logic [CNTW-1:0] cnt = 0;
  logic [DW-1:0] prog_data = 0, rd_data, ph_wdata, ph_rdata = 0;
  logic [LW-1:0] rd_lvl = 0, prog_lvl = 0;
  logic rd_valid, prog_full, ph_req, ph_bank, ph_done = 0, ph_err = 0;
  logic [1:0] ph_op;
  logic [AW-1:0] ph_addr;
  logic busy, done, err, irq_done, irq_err, irq_rd_full, irq_rd_lvl, irq_prog_empty, irq_prog_lvl;

  int checks = 0, failures = 0, n_log = 0, n_done = 0, n_err = 0, lat = 0;
  int log_op [64];
  int log_addr [64];
  int log_data [64];
  int log_bank [64];
  bit err_en = 0;
  int err_addr = 0;

  always #5 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .DW(DW), .CNTW(CNTW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .erase_bank_i(bank),
    .addr_i(addr), .count_i(cnt), .rd_pop_i(rd_pop), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .prog_push_i(prog_push), .prog_data_i(prog_data), .prog_full_o(prog_full),
    .rd_lvl_i(rd_lvl), .prog_lvl_i(prog_lvl), .ph_req_o(ph_req), .ph_op_o(ph_op),
    .ph_bank_o(ph_bank), .ph_addr_o(ph_addr), .ph_wdata_o(ph_wdata), .ph_done_i(ph_done),
    .ph_err_i(ph_err), .ph_rdata_i(ph_rdata), .ph_init_busy_i(init_busy), .busy_o(busy),
    .done_o(done), .err_o(err), .irq_done_o(irq_done), .irq_err_o(irq_err),
    .irq_rd_full_o(irq_rd_full), .irq_rd_lvl_o(irq_rd_lvl),
    .irq_prog_empty_o(irq_prog_empty), .irq_prog_lvl_o(irq_prog_lvl)
  );

  function automatic int rd_word(int a);
    return ((a * 257) ^ 16'h5a3c) & 16'hffff;
  endfunction
  function automatic int pr_word(int k);
    return (k * 4099 + 17) & 16'hffff;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // physical flash model, fixed latency
  initial begin
    int wc = 0;
    forever begin
      @(negedge clk);
      if (ph_done) begin
        ph_done = 0; ph_err = 0; wc = 0;
      end else if (ph_req) begin
        if (wc >= lat) begin
          ph_done = 1;
          ph_rdata = DW'(rd_word(int'(ph_addr)));
          ph_err = err_en && (int'(ph_addr) == err_addr);
          if (n_log < 64) begin
            log_op[n_log] = int'(ph_op); log_addr[n_log] = int'(ph_addr);
            log_data[n_log] = int'(ph_wdata); log_bank[n_log] = int'(ph_bank);
          end
          n_log++;
        end else wc++;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (irq_done) n_done++;
    if (irq_err) n_err++;
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic start_op(input int o, input int b, input int a, input int c);
    @(negedge clk);
    op = 2'(o); bank = b[0]; addr = AW'(a); cnt = CNTW'(c); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic push_word(input int d);
    @(negedge clk);
    while (prog_full) @(negedge clk);
    prog_push = 1; prog_data = DW'(d);
    @(negedge clk);
    prog_push = 0;
  endtask

  task automatic drain_check(input int base, input int words, input string req);
    int got = 0;
    for (int i = 0; i < 4000 && got < words; i++) begin
      @(negedge clk);
      if (rd_valid) begin
        chk(req, int'(rd_data), rd_word(base + got));
        rd_pop = 1; got++;
      end else rd_pop = 0;
    end
    @(negedge clk);
    rd_pop = 0;
    chk(req, got, words);
  endtask

  initial begin
    int pk = 0;
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset busy", busy, 0);
    chk("R8 reset done", done, 0);
    chk("R4 reset req", ph_req, 0);
    chk("R9 reset prog empty", irq_prog_empty, 1);
    chk("R9 reset rd full", irq_rd_full, 0);
    chk("R1 reset rd valid", rd_valid, 0);

    // R1 short read sweep over length and latency
    for (int l = 0; l < 3; l++) begin
      for (int n = 0; n < DEPTH; n++) begin
        int base = 10 + n * 7 + l * 40;
        lat = l; n_log = 0; d0 = n_done;
        start_op(0, 0, base, n);
        wait_idle();
        chk("R8 done set", done, 1);
        chk("R8 one done pulse", n_done - d0, 1);
        chk("R1 word count", n_log, n + 1);
        for (int i = 0; i <= n; i++) begin
          chk("R1 addr", log_addr[i], base + i);
          chk("R1 op", log_op[i], 0);
        end
        drain_check(base, n + 1, "R1 data");
      end
    end

    // R2 long read stalls on full FIFO, R6 start ignored while busy
    lat = 1; n_log = 0;
    start_op(0, 0, 100, 7);
    repeat (60) @(negedge clk);
    chk("R2 stalled busy", busy, 1);
    chk("R2 stalled count", n_log, DEPTH);
    chk("R2 no req when full", ph_req, 0);
    chk("R9 rd full", irq_rd_full, 1);
    rd_lvl = 3;
    #1 chk("R9 rd lvl", irq_rd_lvl, 1);
    start_op(2, 1, 5, 0);
    drain_check(100, 8, "R2 data");
    wait_idle();
    chk("R6 ignored start", n_log, 8);
    for (int i = 0; i < 8; i++) chk("R6 op stays read", log_op[i], 0);

    // R9 read level sweep
    n_log = 0;
    start_op(0, 0, 60, 2);
    wait_idle();
    for (int v = 0; v <= DEPTH; v++) begin
      @(negedge clk); rd_lvl = LW'(v);
      #1 chk("R9 rd lvl sweep", irq_rd_lvl, (3 >= v) ? 1 : 0);
    end
    chk("R9 rd not full", irq_rd_full, 0);
    drain_check(60, 3, "R1 data");

    // R3 and R9 program sweep
    for (int k = 1; k <= DEPTH; k++) begin
      for (int i = 0; i < k; i++) push_word(pr_word(pk + i));
      for (int v = 0; v <= DEPTH; v++) begin
        @(negedge clk); prog_lvl = LW'(v);
        #1 chk("R9 prog lvl sweep", irq_prog_lvl, (k <= v) ? 1 : 0);
      end
      chk("R9 prog not empty", irq_prog_empty, 0);
      chk("R9 prog full", prog_full, (k == DEPTH) ? 1 : 0);
      n_log = 0; lat = k % 3;
      start_op(1, 0, 30 + k, k - 1);
      wait_idle();
      chk("R3 word count", n_log, k);
      for (int i = 0; i < k; i++) begin
        chk("R3 addr", log_addr[i], 30 + k + i);
        chk("R3 data", log_data[i], pr_word(pk + i));
        chk("R3 op", log_op[i], 1);
      end
      pk += k;
      chk("R9 prog empty after", irq_prog_empty, 1);
    end

    // R3 stall on empty program FIFO
    n_log = 0; lat = 0;
    push_word(pr_word(pk)); push_word(pr_word(pk + 1));
    start_op(1, 0, 200, 5);
    repeat (40) @(negedge clk);
    chk("R3 stalled count", n_log, 2);
    chk("R3 stalled busy", busy, 1);
    chk("R3 no req when empty", ph_req, 0);
    for (int i = 2; i < 6; i++) push_word(pr_word(pk + i));
    wait_idle();
    chk("R3 resumed count", n_log, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R3 addr", log_addr[i], 200 + i);
      chk("R3 data", log_data[i], pr_word(pk + i));
    end
    pk += 6;

    // R5 erase page and bank
    for (int b = 0; b < 2; b++) begin
      n_log = 0; lat = 2;
      start_op(2, b, 51 + b, 9);
      wait_idle();
      chk("R5 one request", n_log, 1);
      chk("R5 op", log_op[0], 2);
      chk("R5 addr", log_addr[0], 51 + b);
      chk("R5 bank", log_bank[0], b);
      chk("R8 done", done, 1);
    end

    // R6 init busy blocks start
    init_busy = 1; n_log = 0;
    start_op(0, 0, 9, 0);
    repeat (5) @(negedge clk);
    chk("R6 init busy no start", busy, 0);
    chk("R6 init busy no req", n_log, 0);
    init_busy = 0;

    // R7 error ends operation
    err_en = 1; err_addr = 72; n_log = 0; lat = 1; d0 = n_err;
    start_op(0, 0, 70, 5);
    wait_idle();
    chk("R7 err set", err, 1);
    chk("R7 done set", done, 1);
    chk("R7 err pulse", n_err - d0, 1);
    chk("R7 stopped", n_log, 3);
    drain_check(70, 2, "R7 data");
    chk("R7 bad word dropped", rd_valid, 0);
    err_en = 0; n_log = 0;
    start_op(0, 0, 90, 0);
    chk("R8 err cleared", err, 0);
    chk("R8 done cleared", done, 0);
    wait_idle();
    chk("R8 done again", done, 1);
    drain_check(90, 1, "R1 data");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule